// File: doc/BRIEF.md
# Receive Frame FIFO with Read-Address Lookahead

This block holds received frames as a stream of 32-bit words in a circular memory whose size is a power of two. A frame-storing controller pushes words one per cycle and then either publishes the finished frame with a commit strobe or throws it away with an abort strobe. Before it publishes, the controller may also patch one word of the pending frame, such as a late timestamp. Software drains the buffer through a single data port. Each read strobe consumes one word, and reads on consecutive cycles stream with no idle cycle in between.

The memory has a registered read port so that it can map onto block RAM. To hide that one-cycle latency, the RAM read address looks one word ahead during a read. The next word is therefore already on the output register when the following read arrives. A small counter reports how many words of the current frame are still unread. It takes this value from a count field in each frame's first word.

Top module: `rxq_frame_buf`

## Requirements
- R1: DEPTH must be a power of two between 2 and 4096. Any other value stops elaboration with an error.
- R2: After reset, empty_o is 1, overrun_o is 0, frame_left_o is 0 and rd_data_o is 0.
- R3: Each read strobe while not empty advances the read position by one word, wrapping modulo DEPTH. A read strobe while empty changes nothing: the next word read after data arrives is the first stored word.
- R4: rd_data_o always shows the word at the read position. During reads on consecutive cycles, each cycle presents the next stored word with no gap cycle.
- R5: While empty_o is 1, rd_data_o is all zeros.
- R6: Words written with wr_en_i stay invisible until commit_i. On commit, all words since the last commit or abort become readable on the next cycle. commit_i must not share a cycle with wr_en_i or wr_ts_i.
- R7: abort_i discards the pending words and returns the write position to the last committed position. The next frame is stored from there.
- R8: A write attempted while committed plus pending words equal DEPTH is dropped, and overrun_o is 1 from the next cycle. Later writes of that frame are also dropped. Ending the frame clears overrun_o, and a commit of such a frame acts as an abort.
- R9: Exactly DEPTH words can be held. A completely full buffer reports empty_o = 0 and returns all DEPTH words in order.
- R10: wr_ts_i writes wr_data_i into the pending frame at word offset TS_SLOT from the frame's first word. It neither moves the write position nor uses free space.
- R11: A read while frame_left_o is 0 loads frame_left_o from bits [CNT_LSB +: CNT_W] of the word being read. Any other read decrements frame_left_o by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Append wr_data_i to the pending frame |
| wr_ts_i | input | 1 | Patch wr_data_i at offset TS_SLOT of the pending frame |
| wr_data_i | input | 32 | Write data |
| commit_i | input | 1 | Publish the pending frame |
| abort_i | input | 1 | Discard the pending frame |
| rd_en_i | input | 1 | Consume the word on rd_data_o |
| rd_data_o | output | 32 | Word at the read position, zero when empty |
| empty_o | output | 1 | No committed word is unread |
| overrun_o | output | 1 | The pending frame lost a word for lack of space |
| frame_left_o | output | CNT_W | Unread words left in the current frame after its first word |

## Verification
Some rules are checked on every cycle by properties. The read position steps by exactly one per accepted read and holds otherwise. The registered RAM address always equals the read position one cycle later, which is what makes burst reads gap-free. A full-buffer write raises the overrun flag. An abort rolls the write position back, and a timestamp patch leaves it still. The frame counter decrements. Only the bench scenarios can show that the words come out in the right order and with the right values. They cover frames of varied length, wrap-around of the circular memory, invisibility before commit, abort, timestamp patching, and the full-versus-empty distinction at exactly DEPTH words.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int WORD_W = 32;
  localparam int MAX_DEPTH = 4096;

  typedef logic [WORD_W-1:0] word_t;

  // Accepts only powers of two in [2, MAX_DEPTH]
  function automatic bit depth_ok(input int d);
    return (d >= 2) && (d <= MAX_DEPTH) && ((d & (d - 1)) == 0);
  endfunction

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/rxq_ram.sv
module rxq_ram
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output word_t         rdata_o
);
  word_t mem [DEPTH];
  word_t rdata_q;

  // Write-only port
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // Read-only port, registered one cycle after the address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rxq_wrctl.sv
module rxq_wrctl #(
  parameter int DEPTH   = 64,
  parameter int TS_SLOT = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_ts_i,
  input  logic          commit_i,
  input  logic          abort_i,
  input  logic          rd_fire_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_waddr_o,
  output logic          empty_o,
  output logic          overrun_o
);
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;    // next free slot, pending frame included
  logic [AW-1:0] com_ptr_q, com_ptr_d;  // first slot of the pending frame
  logic [CW-1:0] occ_com_q, occ_com_d;  // committed unread words
  logic [CW-1:0] pend_q, pend_d;        // uncommitted words
  logic          ovr_q, ovr_d;

  logic full, wr_ok, drop, end_frame, good_commit;

  always_comb begin
    full        = (occ_com_q + pend_q) == CW'(DEPTH);
    wr_ok       = wr_en_i && !full && !ovr_q;
    drop        = wr_en_i && (full || ovr_q);
    end_frame   = commit_i || abort_i;
    good_commit = commit_i && !abort_i && !ovr_q && !drop;

    wr_ptr_d  = wr_ptr_q + AW'(wr_ok);
    com_ptr_d = com_ptr_q;
    pend_d    = pend_q + CW'(wr_ok);
    occ_com_d = occ_com_q - CW'(rd_fire_i);
    ovr_d     = ovr_q || drop;

    if (end_frame) begin
      pend_d = '0;
      ovr_d  = 1'b0;
      if (good_commit) begin
        com_ptr_d = wr_ptr_d;
        occ_com_d = occ_com_q - CW'(rd_fire_i) + pend_q + CW'(wr_ok);
      end else begin
        wr_ptr_d = com_ptr_q;  // roll back
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      com_ptr_q <= '0;
      occ_com_q <= '0;
      pend_q    <= '0;
      ovr_q     <= 1'b0;
    end else begin
      wr_ptr_q  <= wr_ptr_d;
      com_ptr_q <= com_ptr_d;
      occ_com_q <= occ_com_d;
      pend_q    <= pend_d;
      ovr_q     <= ovr_d;
    end
  end

  assign ram_we_o    = wr_ok || wr_ts_i;
  assign ram_waddr_o = wr_ts_i ? (com_ptr_q + AW'(TS_SLOT)) : wr_ptr_q;
  assign empty_o     = (occ_com_q == '0);
  assign overrun_o   = ovr_q;

  // R8: a write into a full buffer raises the overrun flag
  p_ovr_on_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full && !end_frame) |=> overrun_o);

  // R7: abort returns the write position to the committed one
  p_abort_rollback_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (wr_ptr_q == $past(com_ptr_q)));

  // R6: commit stands alone on the write side
  p_commit_alone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (!wr_en_i && !wr_ts_i));

  // R6: a successful commit of words makes the buffer non-empty
  p_commit_publish_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_commit && (pend_q != '0)) |=> !empty_o);

  // R9: occupancy never exceeds the depth
  p_occ_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_com_q + pend_q) <= CW'(DEPTH));

  // R10: a timestamp patch does not move the write position
  p_ts_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ts_i && !wr_en_i && !abort_i) |=> $stable(wr_ptr_q));
endmodule

// File: rtl/rxq_rdptr.sv
module rxq_rdptr #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_fire_i,
  input  logic [CNT_W-1:0] hdr_cnt_i,
  output logic [AW-1:0]    ram_raddr_o,
  output logic [CNT_W-1:0] frame_left_o
);
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d, rd_ptr_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Incremented pointer: next pointer value and lookahead read address
  assign rd_ptr_inc  = rd_ptr_q + AW'(1);
  assign ram_raddr_o = rd_fire_i ? rd_ptr_inc : rd_ptr_q;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (rd_fire_i) begin
      rd_ptr_d = rd_ptr_inc;
      cnt_d    = (cnt_q == '0) ? hdr_cnt_i : (cnt_q - CNT_W'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign frame_left_o = cnt_q;

  // R3: one-word step per accepted read, hold otherwise
  p_rd_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire_i |=> (rd_ptr_q == $past(rd_ptr_q) + AW'(1)));
  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire_i |=> $stable(rd_ptr_q));

  // R4: the address the RAM registered last cycle is the current position
  p_lookahead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rd_ptr_q == $past(ram_raddr_o)));

  // R11: counter decrements on reads inside a frame
  p_cnt_dec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/rxq_frame_buf.sv
module rxq_frame_buf
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TS_SLOT = 1,
  parameter int CNT_LSB = 0,
  parameter int CNT_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_ts_i,
  input  logic [31:0]      wr_data_i,
  input  logic             commit_i,
  input  logic             abort_i,
  input  logic             rd_en_i,
  output logic [31:0]      rd_data_o,
  output logic             empty_o,
  output logic             overrun_o,
  output logic [CNT_W-1:0] frame_left_o
);
  localparam int AW = $clog2(DEPTH);

  // R1: elaboration-time size checks
  if (!depth_ok(DEPTH)) begin : g_bad_depth
    $error("rxq_frame_buf: DEPTH must be a power of two in 2..4096");
  end
  if ((CNT_LSB + CNT_W) > WORD_W) begin : g_bad_field
    $error("rxq_frame_buf: count field exceeds the word");
  end

  logic          rst_n;
  logic          ram_we, rd_fire;
  logic [AW-1:0] ram_waddr, ram_raddr;
  word_t         ram_rdata;

  rxq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign rd_fire = rd_en_i && !empty_o;

  rxq_wrctl #(.DEPTH(DEPTH), .TS_SLOT(TS_SLOT)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_ts_i     (wr_ts_i),
    .commit_i    (commit_i),
    .abort_i     (abort_i),
    .rd_fire_i   (rd_fire),
    .ram_we_o    (ram_we),
    .ram_waddr_o (ram_waddr),
    .empty_o     (empty_o),
    .overrun_o   (overrun_o)
  );

  rxq_rdptr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .rd_fire_i    (rd_fire),
    .hdr_cnt_i    (ram_rdata[CNT_LSB +: CNT_W]),
    .ram_raddr_o  (ram_raddr),
    .frame_left_o (frame_left_o)
  );

  rxq_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (wr_data_i),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  assign rd_data_o = empty_o ? '0 : ram_rdata;

  // R3: a read strobe while empty does not change the frame counter
  p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && empty_o) |=> $stable(frame_left_o));
endmodule

// File: tb/sim_rxq_frame_buf.sv
`timescale 1ns/1ps
module sim_rxq_frame_buf;
  localparam int DEPTH   = 16;
  localparam int TS_SLOT = 1;
  localparam int CNT_W   = 5;

  // Vector table: two frame lengths per entry and the words to drain
  localparam int NVEC = 8;
  localparam int LEN_A [NVEC] = '{3, 5, 1, 4, 6, 2, 0, 10};
  localparam int LEN_B [NVEC] = '{0, 2, 7, 4, 1, 2, 0, 3};
  localparam int EXP_N [NVEC] = '{5, 9, 10, 10, 9, 6, 2, 15};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, wr_en, wr_ts, commit, abort, rd_en;
  logic [31:0]      wr_data, rd_data;
  logic             empty, overrun;
  logic [CNT_W-1:0] frame_left;

  rxq_frame_buf #(.DEPTH(DEPTH), .TS_SLOT(TS_SLOT), .CNT_LSB(0), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ts_i(wr_ts),
    .wr_data_i(wr_data), .commit_i(commit), .abort_i(abort), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty), .overrun_o(overrun),
    .frame_left_o(frame_left)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [$];
  logic [31:0] pend [$];
  logic [CNT_W-1:0] mcnt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int len, input int tag);
    return (32'(tag) << 8) | 32'(len);
  endfunction

  function automatic logic [31:0] dword(input int tag, input int i);
    return 32'hD000_0000 | (32'(tag) << 8) | 32'(i);
  endfunction

  task automatic wr_word(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    pend.push_back(w);
  endtask

  task automatic put_frame(input int len, input int tag);
    wr_word(hdr(len, tag));
    for (int i = 1; i <= len; i++) wr_word(dword(tag, i));
  endtask

  task automatic commit_frame(input bit keep);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    if (keep) foreach (pend[i]) model.push_back(pend[i]);
    pend.delete();
  endtask

  task automatic abort_frame();
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    pend.delete();
  endtask

  task automatic ts_write(input logic [31:0] w);
    wr_ts = 1'b1; wr_data = w;
    @(negedge clk);
    wr_ts = 1'b0;
    pend[TS_SLOT] = w;
  endtask

  // Back-to-back reads, one word per cycle
  task automatic drain(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [31:0] e;
      e = model.pop_front();
      chk(req, rd_data, e);
      chk("R11 frame_left", 32'(frame_left), 32'(mcnt));
      mcnt = (mcnt == '0) ? e[CNT_W-1:0] : mcnt - CNT_W'(1);
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_ts = 1'b0; commit = 1'b0; abort = 1'b0;
    rd_en = 1'b0; wr_data = '0; mcnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 / R5: reset state
    chk("R2 empty", 32'(empty), 32'd1);
    chk("R2 overrun", 32'(overrun), 32'd0);
    chk("R2 frame_left", 32'(frame_left), 32'd0);
    chk("R5 data zero", rd_data, 32'd0);

    // R3: read while empty is ignored
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R3 empty read", 32'(empty), 32'd1);
    chk("R5 data zero", rd_data, 32'd0);

    // R4 / R11 / R3: vector table, wraps the memory several times
    for (int v = 0; v < NVEC; v++) begin
      put_frame(LEN_A[v], 2 * v);
      commit_frame(1'b1);
      put_frame(LEN_B[v], 2 * v + 1);
      commit_frame(1'b1);
      chk("R6 visible", 32'(empty), 32'd0);
      drain(EXP_N[v], "R4 burst word");
      chk("R3 drained", 32'(empty), 32'd1);
      chk("R5 data zero", rd_data, 32'd0);
    end

    // R6: pending words invisible until commit
    put_frame(2, 40);
    chk("R6 hidden", 32'(empty), 32'd1);
    chk("R6 hidden data", rd_data, 32'd0);
    commit_frame(1'b1);
    chk("R6 published", 32'(empty), 32'd0);
    chk("R6 first word", rd_data, hdr(2, 40));
    drain(3, "R6 word");

    // R7: abort rolls back
    put_frame(2, 41);
    abort_frame();
    chk("R7 after abort", 32'(empty), 32'd1);
    put_frame(1, 42);
    commit_frame(1'b1);
    drain(2, "R7 word");
    chk("R7 drained", 32'(empty), 32'd1);

    // R10: timestamp patch
    put_frame(2, 43);
    ts_write(32'h7A5E_0001);
    commit_frame(1'b1);
    drain(3, "R10 word");

    // R8: overrun on a full pending frame, commit acts as abort
    put_frame(15, 44);
    chk("R8 no overrun yet", 32'(overrun), 32'd0);
    wr_word(32'hBAD0_0000);
    chk("R8 overrun set", 32'(overrun), 32'd1);
    chk("R6 still hidden", 32'(empty), 32'd1);
    commit_frame(1'b0);
    chk("R8 commit dropped", 32'(empty), 32'd1);
    chk("R8 overrun cleared", 32'(overrun), 32'd0);

    // R9 / R1: exactly DEPTH words held, full is not empty
    put_frame(15, 45);
    commit_frame(1'b1);
    chk("R9 full not empty", 32'(empty), 32'd0);
    chk("R9 no overrun", 32'(overrun), 32'd0);
    wr_word(32'hBAD0_0001);
    chk("R8 overrun when full", 32'(overrun), 32'd1);
    abort_frame();
    chk("R8 abort clears", 32'(overrun), 32'd0);
    drain(DEPTH, "R9 R1 full word");
    chk("R9 drained", 32'(empty), 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule